// File: doc/BRIEF.md
# Bubble-Tolerant Thermometer ROM Encoder

This block turns the comparator word of a flash quantizer into a numeric code. For a code width of `CODE_W` bits the input is a thermometer word of `2^CODE_W - 1` bits. Bit 0 is the lowest comparator level. An ideal word has every bit below some position set and every bit from there upward clear.

A row detector finds the point where the word steps from ones to zeros. It judges each candidate row from three neighbouring bits, so a lone stray one above the step selects no row. Every selected row reads a Gray-coded entry, and the entries of all selected rows are OR-ed together. The Gray code is then converted to binary. The Gray code, the binary code and a flag for more than one selected row are registered in the same clock edge that samples a valid input word.

Top module: `therm_rom_encoder`

## Requirements
- R1: While `rst_ni` is low, `gray_o`, `bin_o` and `conflict_o` are all zero.
- R2: At a rising edge where `valid_i` is low, none of the outputs changes.
- R3: Suppose `therm_i` at a rising edge with `valid_i` high holds a clean thermometer word with k ones, meaning bits 0 to k-1 set and all others clear. After that edge, `bin_o` equals k, `gray_o` equals k XOR (k >> 1) and `conflict_o` is 0.
- R4: An all-zero word gives code 0. An all-ones word (63 ones at the default width) gives binary 63 and Gray 6'b100000.
- R5: A lone set bit above the step, with clear bits on both sides, selects no row. The outputs then equal those of the same word without that bit.
- R6: Code row c, for c from 0 to 2^CODE_W - 1, is selected when input bits c-2 and c-1 are set and bit c is clear. Bits at negative indices count as set, and bit index 2^CODE_W - 1 counts as clear. `gray_o` becomes the bitwise OR of c XOR (c >> 1) over all selected rows. `conflict_o` becomes 1 exactly when more than one row is selected.
- R7: At all times `bin_o` is the binary value of the Gray code on `gray_o`: bit i of `bin_o` is the XOR of `gray_o` bits i and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Samples `therm_i` at this edge when high |
| therm_i | input | 2^CODE_W-1 | Thermometer word from the comparators, bit 0 lowest |
| gray_o | output | CODE_W | Registered Gray code |
| bin_o | output | CODE_W | Registered binary code |
| conflict_o | output | 1 | Registered flag: more than one row was selected |

## Verification
The assertions assume that `therm_i` and `valid_i` carry known values at every sampled edge and that reset is applied once before use. The bench meets this by driving every input from reset onward, and only on falling edges.

The stimulus walks every clean level from empty to full. It then applies words with a lone stray one, words with a zero hole below the step, words with paired stray ones, and raw random words. Random words are allowed because the row rule in R6 defines an output for any input word.

// File: rtl/therm_enc_pkg.sv
package therm_enc_pkg;
  function automatic int unsigned therm_width(int unsigned code_w);
    return (1 << code_w) - 1;
  endfunction
endpackage

// File: rtl/therm_row_detect.sv
module therm_row_detect #(
  parameter int CODE_W = 6
) (
  input  logic [therm_enc_pkg::therm_width(CODE_W)-1:0] therm_i,
  output logic [(1<<CODE_W)-1:0]                         hit_o,
  output logic                                           multi_o
);
  localparam int THERM_W = therm_enc_pkg::therm_width(CODE_W);
  localparam int ROWS    = 1 << CODE_W;

  // two implied ones below bit 0, one implied zero above the top bit
  logic [THERM_W+2:0] ext;
  assign ext = {1'b0, therm_i, 2'b11};

  for (genvar c = 0; c < ROWS; c++) begin : g_row
    assign hit_o[c] = ext[c] & ext[c+1] & ~ext[c+2];
  end

  assign multi_o = |(hit_o & (hit_o - ROWS'(1)));
endmodule

// File: rtl/therm_gray_rom.sv
module therm_gray_rom #(
  parameter int CODE_W = 6
) (
  input  logic [(1<<CODE_W)-1:0] hit_i,
  output logic [CODE_W-1:0]      gray_o
);
  localparam int ROWS = 1 << CODE_W;

  always_comb begin
    gray_o = '0;
    for (int c = 0; c < ROWS; c++) begin
      if (hit_i[c]) gray_o = gray_o | CODE_W'(c ^ (c >> 1));
    end
  end
endmodule

// File: rtl/gray_to_bin.sv
module gray_to_bin #(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] gray_i,
  output logic [CODE_W-1:0] bin_o
);
  always_comb begin
    bin_o[CODE_W-1] = gray_i[CODE_W-1];
    for (int i = CODE_W - 2; i >= 0; i--) begin
      bin_o[i] = bin_o[i+1] ^ gray_i[i];
    end
  end
endmodule

// File: rtl/therm_rom_encoder.sv
module therm_rom_encoder #(
  parameter int CODE_W = 6
) (
  input  logic                                           clk_i,
  input  logic                                           rst_ni,
  input  logic                                           valid_i,
  input  logic [therm_enc_pkg::therm_width(CODE_W)-1:0] therm_i,
  output logic [CODE_W-1:0]                              gray_o,
  output logic [CODE_W-1:0]                              bin_o,
  output logic                                           conflict_o
);
  localparam int ROWS = 1 << CODE_W;

  logic [ROWS-1:0]   hit;
  logic              multi;
  logic [CODE_W-1:0] gray_d;
  logic [CODE_W-1:0] bin_d;

  therm_row_detect #(.CODE_W(CODE_W)) u_detect (
    .therm_i (therm_i),
    .hit_o   (hit),
    .multi_o (multi)
  );

  therm_gray_rom #(.CODE_W(CODE_W)) u_rom (
    .hit_i  (hit),
    .gray_o (gray_d)
  );

  gray_to_bin #(.CODE_W(CODE_W)) u_g2b (
    .gray_i (gray_d),
    .bin_o  (bin_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gray_o     <= '0;
      bin_o      <= '0;
      conflict_o <= 1'b0;
    end else if (valid_i) begin
      gray_o     <= gray_d;
      bin_o      <= bin_d;
      conflict_o <= multi;
    end
  end
endmodule

// File: rtl/therm_rom_encoder_chk.sv
module therm_rom_encoder_chk #(
  parameter int CODE_W = 6
) (
  input logic                                           clk_i,
  input logic                                           rst_ni,
  input logic                                           valid_i,
  input logic [therm_enc_pkg::therm_width(CODE_W)-1:0] therm_i,
  input logic [CODE_W-1:0]                              gray_o,
  input logic [CODE_W-1:0]                              bin_o,
  input logic                                           conflict_o
);
  localparam int THERM_W = therm_enc_pkg::therm_width(CODE_W);

  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_zero : assert (gray_o == '0 && bin_o == '0 && !conflict_o);
    end
  end

  a_r2_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable({gray_o, bin_o, conflict_o}));

  a_r3_clean_code : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ((therm_i & (therm_i + THERM_W'(1))) == '0))
    |=> (!conflict_o && bin_o == CODE_W'($countones($past(therm_i)))));

  a_r4_all_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && therm_i == '0) |=> (gray_o == '0 && bin_o == '0));

  a_r4_all_ones : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && &therm_i) |=> (bin_o == CODE_W'(THERM_W) && !conflict_o));

  a_r7_gray_bin : assert property (@(posedge clk_i) disable iff (!rst_ni)
    gray_o == (bin_o ^ (bin_o >> 1)));
endmodule

bind therm_rom_encoder therm_rom_encoder_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .therm_i    (therm_i),
  .gray_o     (gray_o),
  .bin_o      (bin_o),
  .conflict_o (conflict_o)
);

// File: tb/tb_therm_rom_encoder.sv
module tb_therm_rom_encoder;
  localparam int CODE_W  = 6;
  localparam int THERM_W = 63;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               valid_i = 1'b0;
  logic [THERM_W-1:0] therm_i = '0;
  logic [CODE_W-1:0]  gray_o;
  logic [CODE_W-1:0]  bin_o;
  logic               conflict_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [CODE_W-1:0] exp_g = '0;
  logic [CODE_W-1:0] exp_b = '0;
  logic              exp_c = 1'b0;

  always #10ns clk_i = ~clk_i;

  therm_rom_encoder #(.CODE_W(CODE_W)) dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .valid_i (valid_i), .therm_i (therm_i),
    .gray_o (gray_o), .bin_o (bin_o), .conflict_o (conflict_o)
  );

  function automatic bit tbit(logic [THERM_W-1:0] t, int i);
    if (i < 0) return 1'b1;
    if (i >= THERM_W) return 1'b0;
    return t[i];
  endfunction

  // behavioural reference built from the row rule (R6) and Gray decoding (R7)
  task automatic ref_model(input logic [THERM_W-1:0] t, output logic [CODE_W-1:0] g,
                           output logic [CODE_W-1:0] b, output logic cf);
    int n = 0;
    g = '0;
    for (int c = 0; c <= THERM_W; c++) begin
      if (tbit(t, c - 2) && tbit(t, c - 1) && !tbit(t, c)) begin
        n++;
        g = g | CODE_W'(c ^ (c >> 1));
      end
    end
    cf = (n > 1);
    for (int i = 0; i < CODE_W; i++) b[i] = ^(g >> i);
  endtask

  function automatic logic [THERM_W-1:0] clean(int k);
    logic [THERM_W-1:0] v = '0;
    for (int i = 0; i < k; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (gray_o !== exp_g || bin_o !== exp_b || conflict_o !== exp_c) begin
      errors++;
      $display("FAIL %s: gray=%b bin=%0d conflict=%b expected gray=%b bin=%0d conflict=%b",
               tag, gray_o, bin_o, conflict_o, exp_g, exp_b, exp_c);
    end
  endtask

  task automatic step(input logic v, input logic [THERM_W-1:0] t, input string tag);
    valid_i = v;
    therm_i = t;
    @(posedge clk_i);
    if (v) ref_model(t, exp_g, exp_b, exp_c);
    @(negedge clk_i);
    check(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [THERM_W-1:0] w;
    // R1: reset state, with a busy input applied
    valid_i = 1'b1;
    therm_i = clean(40);
    repeat (3) @(negedge clk_i);
    check("R1 reset");
    rst_ni = 1'b1;
    valid_i = 1'b0;

    // R3: every clean level
    for (int k = 0; k <= THERM_W; k++) step(1'b1, clean(k), "R3 clean level");

    // R4: both extremes
    step(1'b1, '0, "R4 all zero");
    if (gray_o !== 6'b000000) begin errors++; $display("FAIL R4: gray=%b expected 000000", gray_o); end
    checks++;
    step(1'b1, '1, "R4 all ones");
    if (gray_o !== 6'b100000 || bin_o !== 6'd63) begin
      errors++; $display("FAIL R4: gray=%b bin=%0d expected 100000 63", gray_o, bin_o);
    end
    checks++;

    // R2: valid low keeps the last result regardless of input
    step(1'b1, clean(21), "R2 load");
    step(1'b0, '0, "R2 hold zero");
    step(1'b0, clean(50), "R2 hold level");
    step(1'b0, 63'h2AAA_AAAA_AAAA_AAAA, "R2 hold noise");
    if (bin_o !== 6'd21) begin errors++; $display("FAIL R2: bin=%0d expected 21", bin_o); end
    checks++;

    // R5: lone stray one above the step is ignored
    for (int k = 0; k <= 60; k += 6) begin
      for (int gap = 1; gap <= 2 && k + gap < THERM_W - 1; gap++) begin
        w = clean(k);
        w[k + gap] = 1'b1;
        step(1'b1, w, "R5 stray one");
        if (bin_o !== 6'(k) || conflict_o !== 1'b0) begin
          errors++; $display("FAIL R5: bin=%0d conflict=%b expected %0d 0", bin_o, conflict_o, k);
        end
        checks++;
      end
    end

    // R6: zero hole below the step selects a second row
    w = clean(31);
    w[10] = 1'b0;
    step(1'b1, w, "R6 zero hole");
    if (conflict_o !== 1'b1 || gray_o !== (6'(10 ^ 5) | 6'(31 ^ 15))) begin
      errors++; $display("FAIL R6: gray=%b conflict=%b expected %b 1", gray_o, conflict_o,
                         6'(10 ^ 5) | 6'(31 ^ 15));
    end
    checks++;
    // R6: paired stray ones add a row
    w = clean(12);
    w[40] = 1'b1; w[41] = 1'b1;
    step(1'b1, w, "R6 stray pair");
    // R6/R7: arbitrary words
    for (int n = 0; n < 200; n++) begin
      w = {$urandom(), $urandom()};
      step(1'b1, w, "R6 random word");
    end
    for (int n = 0; n < 200; n++) begin
      w = clean(int'($urandom_range(0, THERM_W)));
      w[$urandom_range(0, THERM_W - 1)] ^= 1'b1;
      step(1'b1, w, "R6 single flip");
      if (gray_o !== (bin_o ^ (bin_o >> 1))) begin
        errors++; $display("FAIL R7: gray=%b expected %b", gray_o, bin_o ^ (bin_o >> 1));
      end
      checks++;
    end

    finish_run();
  end
endmodule